// File: doc/BRIEF.md
# Opcode-Triggered Pixel Access Unit

This block sits beside an 8-bit CPU on a bus where one cycle of the CPU's clock is one cycle of `clk`. It watches the opcode-fetch strobe and the data bus. It records each fetched opcode and counts the cycles of the instruction that follows. When an opcode whose low five bits are `00001` (the indexed-indirect group) is still running at its sixth cycle, the block raises a pixel-mode signal. The signal stays high until the next fetch. While the mode is high, reads and writes at or above address `0x1900` no longer reach memory bytes. Each one reaches a single 3-bit pixel of a packed framebuffer instead.

The framebuffer is held as 2 bits per pixel, 4 pixels to a byte, 64 bytes per 256-pixel line, in the same byte RAM that normal accesses use. The last lines of the frame also carry a third colour bit. That bit lives in a separate plane with 8 pixels to a byte. In pixel mode, the high address byte minus `0x19` gives the line and the low address byte gives the column. A pixel write merges into the packed byte with a read-modify-write. A pixel read returns the pixel value right-aligned in the data byte. All other instructions see plain byte memory.

Top module: `pixel_access_unit`

## Requirements
- R1: The SYNC cycle counts as cycle 1. After an opcode with `(op & 0x1F) == 0x01`, `pix_mode` is 0 in cycles 1 to 5 and 1 from cycle 6 until the next cycle in which `bus_sync` is high. It is 0 during that cycle.
- R2: An opcode whose low five bits differ from `00001` never raises `pix_mode`, however long the instruction runs.
- R3: A matching opcode whose next fetch comes in cycle 6 or earlier never raises `pix_mode`.
- R4: In normal mode, a write stores `bus_data` at byte `bus_addr[11:0]` of the 4096-byte RAM. A read returns that byte on `rd_data` two cycles after the read cycle. `rd_data` holds its value until the next accepted read shows up.
- R5: While `pix_mode` is high, addresses below `0x1900` behave exactly as in R4.
- R6: A pixel write at address `{hi, x}` with line `L = hi - 0x19` below 48 replaces only bits `2*(x%4)+1 : 2*(x%4)` of byte `L*64 + x/4` with `bus_data[1:0]`. Pixel 0 sits in the low bits. The other bits of that byte are unchanged.
- R7: The third colour bit is updated from `bus_data[2]` only by a pixel write to lines 32 to 47. On lines 0 to 31, `bus_data[2]` is ignored.
- R8: A pixel read returns `{5'b0, b2, p[1:0]}` two cycles later. Here `p` is the 2-bit pixel and `b2` is the third-plane bit on lines 32 to 47, or 0 on other lines.
- R9: In pixel mode, a line of 48 or more (high byte `0x49` and up) makes a write change nothing and a read return `0x00`.
- R10: Any access in the cycle right after an accepted pixel write is discarded. That cycle belongs to the write-back.
- R11: Reset clears `pix_mode` and `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CPU bus cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_sync | input | 1 | High in an opcode-fetch cycle |
| bus_addr | input | 16 | CPU address |
| bus_data | input | 8 | Data bus value: the opcode in a fetch cycle, the write data in a write cycle |
| bus_rd | input | 1 | Memory read in this cycle |
| bus_wr | input | 1 | Memory write in this cycle |
| rd_data | output | 8 | Read result, registered |
| pix_mode | output | 1 | Pixel addressing is active for this cycle |

## Verification
`pix_mode` follows the inputs of the current cycle. The bench drives each cycle after the falling edge and compares `pix_mode` against the model's cycle number at that time, so cycles 5 and 6 of every matching instruction are told apart. Read data passes through two registers: the synchronous RAM and the output register. The reference model therefore holds each read result in a one-slot queue and expects it two cycles after the read. The literal checks read `rd_data` at the end of the second idle cycle after the read. A dropped access after a pixel write is detected by reading the target byte back later with a normal read.

// File: rtl/pam_pkg.sv
package pam_pkg;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_BYTE = 2'd1,
    RK_PIX  = 2'd2,
    RK_ZERO = 2'd3
  } rd_kind_e;

  // Pixel-address decode shared between the map and the memory stage.
  typedef struct packed {
    logic       pix_sel;
    logic       line_ok;
    logic       in_p3;
    logic [1:0] lane;
    logic [2:0] bsel;
  } pix_dec_t;

  function automatic logic [1:0] lane_get(input logic [7:0] b, input logic [1:0] l);
    case (l)
      2'd0:    return b[1:0];
      2'd1:    return b[3:2];
      2'd2:    return b[5:4];
      default: return b[7:6];
    endcase
  endfunction

  function automatic logic [7:0] lane_put(input logic [7:0] b, input logic [1:0] l,
                                          input logic [1:0] v);
    logic [7:0] r;
    r = b;
    r[{l, 1'b0} +: 2] = v;
    return r;
  endfunction

endpackage

// File: rtl/pam_op_watch.sv
module pam_op_watch #(
  parameter logic [7:0] OP_MASK  = 8'h1F,
  parameter logic [7:0] OP_MATCH = 8'h01,
  parameter int         MIN_CYC  = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync,
  input  logic [7:0] data,
  output logic       mode
);
  localparam int CW = $clog2(MIN_CYC + 2) + 1;
  localparam logic [CW-1:0] CMAX  = '1;
  localparam logic [CW-1:0] CTRIG = CW'(MIN_CYC);

  logic [7:0]    op_q;
  logic [CW-1:0] cnt_q;   // number of the current non-fetch cycle
  logic          mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else if (sync) begin
      op_q   <= data;
      cnt_q  <= CW'(2);
      mode_q <= 1'b0;
    end else begin
      if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CTRIG && (op_q & OP_MASK) == OP_MATCH) mode_q <= 1'b1;
    end
  end

  assign mode = mode_q & ~sync;

endmodule

// File: rtl/pam_addr_map.sv
module pam_addr_map
  import pam_pkg::*;
#(
  parameter int         RAM_AW   = 12,
  parameter int         P3_AW    = 9,
  parameter int         LINES    = 48,
  parameter int         P3_LINES = 16,
  parameter logic [7:0] BASE_HI  = 8'h19
) (
  input  logic              mode,
  input  logic [15:0]       addr,
  output pix_dec_t          dec,
  output logic [RAM_AW-1:0] byte_idx,
  output logic [P3_AW-1:0]  p3_idx
);
  localparam logic [7:0] LINE_LIM = 8'(LINES);
  localparam logic [7:0] P3_FIRST = 8'(LINES - P3_LINES);

  logic [7:0] line, p3_line, x;

  always_comb begin
    x       = addr[7:0];
    line    = addr[15:8] - BASE_HI;
    p3_line = line - P3_FIRST;
    dec.pix_sel = mode && (addr[15:8] >= BASE_HI);
    dec.line_ok = line < LINE_LIM;
    dec.in_p3   = (line >= P3_FIRST) && dec.line_ok;
    dec.lane    = x[1:0];
    dec.bsel    = x[2:0];
    if (dec.pix_sel) byte_idx = RAM_AW'({2'b00, line, x[7:2]});
    else             byte_idx = addr[RAM_AW-1:0];
    p3_idx = P3_AW'({p3_line, x[7:3]});
  end

endmodule

// File: rtl/pam_pixel_mem.sv
module pam_pixel_mem
  import pam_pkg::*;
#(
  parameter int RAM_AW   = 12,
  parameter int P3_AW    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wr,
  input  pix_dec_t          dec,
  input  logic [RAM_AW-1:0] byte_idx,
  input  logic [P3_AW-1:0]  p3_idx,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_data
);
  localparam int DEPTH    = 1 << RAM_AW;
  localparam int P3_DEPTH = 1 << P3_AW;

  logic [7:0] mem   [DEPTH];
  logic [7:0] p3mem [P3_DEPTH];
  logic [7:0] q, q3;

  // write-back stage of a pixel read-modify-write
  logic              wb_pend, wb_p3;
  logic [RAM_AW-1:0] wb_idx;
  logic [P3_AW-1:0]  wb_p3idx;
  logic [1:0]        wb_lane;
  logic [2:0]        wb_bsel;
  logic [2:0]        wb_val;

  // read stage
  rd_kind_e   s1_kind;
  logic [1:0] s1_lane;
  logic [2:0] s1_bsel;
  logic       s1_p3;

  logic              acc_ok, pw, nw, rd_ok;
  logic              ram_we, p3_we;
  logic [RAM_AW-1:0] ram_a;
  logic [P3_AW-1:0]  p3_a;
  logic [7:0]        ram_wd, p3_wd;

  always_comb begin
    acc_ok = (rd | wr) & ~wb_pend;
    pw     = acc_ok & wr & dec.pix_sel & dec.line_ok;
    nw     = acc_ok & wr & ~dec.pix_sel;
    rd_ok  = acc_ok & rd & ~wr;
    ram_we = wb_pend | nw;
    ram_a  = wb_pend ? wb_idx : byte_idx;
    ram_wd = wb_pend ? lane_put(q, wb_lane, wb_val[1:0]) : wdata;
    p3_we  = wb_pend & wb_p3;
    p3_a   = wb_pend ? wb_p3idx : p3_idx;
    p3_wd  = q3;
    p3_wd[wb_bsel] = wb_val[2];
  end

  // single-port byte RAM, read-first when not writing
  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_a] <= ram_wd;
    else        q <= mem[ram_a];
  end

  always_ff @(posedge clk) begin
    if (p3_we) p3mem[p3_a] <= p3_wd;
    else       q3 <= p3mem[p3_a];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_pend <= 1'b0;
    end else begin
      wb_pend <= pw;
    end
    if (pw) begin
      wb_p3    <= dec.in_p3;
      wb_idx   <= byte_idx;
      wb_p3idx <= p3_idx;
      wb_lane  <= dec.lane;
      wb_bsel  <= dec.bsel;
      wb_val   <= wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_kind <= RK_NONE;
      s1_lane <= '0;
      s1_bsel <= '0;
      s1_p3   <= 1'b0;
      rd_data <= '0;
    end else begin
      if (!rd_ok)                s1_kind <= RK_NONE;
      else if (!dec.pix_sel)     s1_kind <= RK_BYTE;
      else if (dec.line_ok)      s1_kind <= RK_PIX;
      else                       s1_kind <= RK_ZERO;
      s1_lane <= dec.lane;
      s1_bsel <= dec.bsel;
      s1_p3   <= dec.in_p3;
      case (s1_kind)
        RK_BYTE: rd_data <= q;
        RK_PIX:  rd_data <= {5'b0, s1_p3 & q3[s1_bsel], lane_get(q, s1_lane)};
        RK_ZERO: rd_data <= '0;
        default: rd_data <= rd_data;
      endcase
    end
  end

endmodule

// File: rtl/pixel_access_unit.sv
module pixel_access_unit
  import pam_pkg::*;
#(
  parameter int         RAM_AW   = 12,
  parameter int         LINES    = 48,
  parameter int         P3_LINES = 16,
  parameter logic [7:0] BASE_HI  = 8'h19,
  parameter logic [7:0] OP_MASK  = 8'h1F,
  parameter logic [7:0] OP_MATCH = 8'h01,
  parameter int         MIN_CYC  = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sync,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_data,
  input  logic        bus_rd,
  input  logic        bus_wr,
  output logic [7:0]  rd_data,
  output logic        pix_mode
);
  localparam int P3_AW = $clog2(P3_LINES * 32);

  pix_dec_t          dec;
  logic [RAM_AW-1:0] byte_idx;
  logic [P3_AW-1:0]  p3_idx;

  pam_op_watch #(
    .OP_MASK(OP_MASK), .OP_MATCH(OP_MATCH), .MIN_CYC(MIN_CYC)
  ) u_watch (
    .clk(clk), .rst(rst), .sync(bus_sync), .data(bus_data), .mode(pix_mode)
  );

  pam_addr_map #(
    .RAM_AW(RAM_AW), .P3_AW(P3_AW), .LINES(LINES),
    .P3_LINES(P3_LINES), .BASE_HI(BASE_HI)
  ) u_map (
    .mode(pix_mode), .addr(bus_addr), .dec(dec),
    .byte_idx(byte_idx), .p3_idx(p3_idx)
  );

  pam_pixel_mem #(
    .RAM_AW(RAM_AW), .P3_AW(P3_AW)
  ) u_mem (
    .clk(clk), .rst(rst), .rd(bus_rd), .wr(bus_wr), .dec(dec),
    .byte_idx(byte_idx), .p3_idx(p3_idx), .wdata(bus_data), .rd_data(rd_data)
  );

endmodule

// File: rtl/pam_checker.sv
module pam_checker #(
  parameter int         LINES    = 48,
  parameter logic [7:0] BASE_HI  = 8'h19,
  parameter logic [7:0] OP_MASK  = 8'h1F,
  parameter logic [7:0] OP_MATCH = 8'h01,
  parameter int         MIN_CYC  = 5
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_sync,
  input logic [7:0] addr_hi,
  input logic [7:0] bus_data,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [7:0] rd_data,
  input logic       pix_mode
);
  localparam int CW = $clog2(MIN_CYC + 2) + 1;
  localparam logic [CW-1:0] CTRIG = CW'(MIN_CYC);
  localparam logic [7:0] HI_LIM = 8'(BASE_HI + LINES);

  logic [CW-1:0] c_cyc;
  logic [7:0]    c_op;
  logic          pw_prev, pr1, pr2, rv1, rv2;
  logic [1:0]    armed;
  logic          match, pix_area, pw_now, rd_now;

  assign match    = (c_op & OP_MASK) == OP_MATCH;
  assign pix_area = pix_mode && addr_hi >= BASE_HI;
  assign pw_now   = pix_area && bus_wr && addr_hi < HI_LIM && !pw_prev;
  assign rd_now   = bus_rd && !bus_wr && !pw_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_cyc <= '0; c_op <= '0; pw_prev <= 1'b0;
      pr1 <= 1'b0; pr2 <= 1'b0; rv1 <= 1'b0; rv2 <= 1'b0; armed <= '0;
    end else begin
      if (bus_sync) begin
        c_op  <= bus_data;
        c_cyc <= CW'(2);
      end else if (c_cyc != '1) begin
        c_cyc <= c_cyc + 1'b1;
      end
      pw_prev <= pw_now;
      pr1 <= rd_now && pix_area;
      pr2 <= pr1;
      rv1 <= rd_now;
      rv2 <= rv1;
      if (armed != 2'd3) armed <= armed + 1'b1;
    end
  end

  // R1: a matching opcode still running after cycle MIN_CYC turns the mode on
  a_r1_mode_on_time: assert property (@(posedge clk) disable iff (rst)
    (!bus_sync && c_cyc == CTRIG && match) |=> (pix_mode || bus_sync));

  // R2/R3: mode only for matching opcodes past cycle MIN_CYC
  a_r3_mode_needs_long_match: assert property (@(posedge clk) disable iff (rst)
    pix_mode |-> (match && c_cyc > CTRIG));

  // R8: pixel read result has zero upper bits
  a_r8_pix_read_high_zero: assert property (@(posedge clk) disable iff (rst)
    pr2 |-> (rd_data[7:3] == 5'd0));

  // R4: read data holds when no read result is due
  a_r4_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (armed == 2'd3 && !rv2) |-> $stable(rd_data));

  // R11: reset clears both outputs
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (rd_data == 8'd0 && !pix_mode));

endmodule

bind pixel_access_unit pam_checker #(
  .LINES(LINES), .BASE_HI(BASE_HI), .OP_MASK(OP_MASK),
  .OP_MATCH(OP_MATCH), .MIN_CYC(MIN_CYC)
) u_pam_checker (
  .clk(clk), .rst(rst), .bus_sync(bus_sync), .addr_hi(bus_addr[15:8]),
  .bus_data(bus_data), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .rd_data(rd_data), .pix_mode(pix_mode)
);

// File: tb/pixel_access_unit_test.sv
module pixel_access_unit_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sync = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  rd_data;
  logic        pix_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pixel_access_unit uut (
    .clk(clk), .rst(rst), .bus_sync(bus_sync), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .rd_data(rd_data), .pix_mode(pix_mode)
  );

  // behavioural reference state
  logic [7:0] m_mem [4096];
  bit         m_p3  [16][256];
  int         m_cyc = 0;
  logic [7:0] m_op  = '0;
  bit         m_wb  = 0;
  logic [7:0] m_cur = '0;
  bit         m_pv  = 0;
  logic [7:0] m_pv_val = '0;

  task automatic chk(input string tag, input string what, input logic [7:0] got,
                     input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic cyc(input bit s, input logic [15:0] a, input logic [7:0] d,
                     input bit r, input bit w, input string tag);
    bit mode, res_v;
    logic [7:0] res;
    int line, x;
    @(negedge clk);
    bus_sync = s; bus_addr = a; bus_data = d; bus_rd = r; bus_wr = w;
    #1;
    if (s) m_cyc = 1; else if (m_cyc < 100) m_cyc++;
    mode = !s && m_cyc >= 6 && ((m_op & 8'h1F) == 8'h01);
    chk(tag, "pix_mode", {7'd0, pix_mode}, {7'd0, mode});
    chk(tag, "rd_data", rd_data, m_cur);
    if (s) m_op = d;
    res_v = 0; res = '0;
    line = int'(a[15:8]) - 25; x = int'(a[7:0]);
    if (m_wb) begin
      m_wb = 0;                              // R10: access dropped
    end else if (w) begin
      if (mode && a[15:8] >= 8'h19) begin
        if (line < 48) begin
          m_mem[line*64 + x/4][2*(x%4) +: 2] = d[1:0];
          if (line >= 32) m_p3[line-32][x] = d[2];
          m_wb = 1;
        end
      end else m_mem[a[11:0]] = d;
    end else if (r) begin
      res_v = 1;
      if (mode && a[15:8] >= 8'h19) begin
        if (line < 48) begin
          res[1:0] = m_mem[line*64 + x/4][2*(x%4) +: 2];
          res[2]   = (line >= 32) ? m_p3[line-32][x] : 1'b0;
        end
      end else res = m_mem[a[11:0]];
    end
    if (m_pv) m_cur = m_pv_val;
    m_pv = res_v; m_pv_val = res;
  endtask

  task automatic instr(input logic [7:0] op, input int n, input logic [15:0] a,
                       input logic [7:0] d, input bit r, input bit w, input string tag);
    cyc(1'b1, 16'h0, op, 1'b0, 1'b0, tag);
    for (int k = 2; k <= n; k++)
      if (k == n) cyc(1'b0, a, d, r, w, tag);
      else        cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic nwr(input logic [15:0] a, input logic [7:0] d, input string tag);
    instr(8'h8D, 4, a, d, 1'b0, 1'b1, tag);
  endtask

  task automatic pwr(input logic [15:0] a, input logic [7:0] d, input string tag);
    instr(8'h81, 6, a, d, 1'b0, 1'b1, tag);
  endtask

  // read, wait two cycles, then compare with a literal
  task automatic rd_expect(input logic [7:0] op, input int n, input logic [15:0] a,
                           input logic [7:0] exp, input string tag);
    instr(op, n, a, 8'h0, 1'b1, 1'b0, tag);
    cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, tag);
    cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, tag);
    chk(tag, "literal rd_data", rd_data, exp);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11", "rd_data after reset", rd_data, 8'h00);
    chk("R11", "pix_mode after reset", {7'd0, pix_mode}, 8'h00);

    // R4 normal byte path and address wrap
    nwr(16'h0123, 8'h5A, "R4");
    rd_expect(8'hAD, 4, 16'h0123, 8'h5A, "R4");
    nwr(16'h1123, 8'h3C, "R4");
    rd_expect(8'hAD, 4, 16'h0123, 8'h3C, "R4");

    // preload bytes under test
    nwr(16'h0081, 8'hFF, "R4");
    nwr(16'h0140, 8'hFF, "R4");
    nwr(16'h0842, 8'h00, "R4");
    nwr(16'h0C00, 8'hAA, "R4");
    nwr(16'h0200, 8'h11, "R4");

    // R6 lane merge
    pwr(16'h1B05, 8'h01, "R6");
    rd_expect(8'hAD, 4, 16'h0081, 8'hF7, "R6");
    rd_expect(8'hA1, 6, 16'h1B05, 8'h01, "R8");
    pwr(16'h1E00, 8'h01, "R6");
    pwr(16'h1E01, 8'h02, "R6");
    pwr(16'h1E02, 8'h03, "R6");
    pwr(16'h1E03, 8'h00, "R6");
    rd_expect(8'hAD, 4, 16'h0140, 8'h39, "R6");

    // R7 / R8 third plane
    pwr(16'h3A0A, 8'h07, "R7");
    rd_expect(8'hA1, 6, 16'h3A0A, 8'h07, "R8");
    rd_expect(8'hAD, 4, 16'h0842, 8'h30, "R7");
    pwr(16'h3A0A, 8'h01, "R7");
    rd_expect(8'hA1, 6, 16'h3A0A, 8'h01, "R7");
    pwr(16'h1B05, 8'h06, "R7");
    rd_expect(8'hA1, 6, 16'h1B05, 8'h02, "R7");

    // R9 line out of range
    pwr(16'h4900, 8'h03, "R9");
    rd_expect(8'hAD, 4, 16'h0C00, 8'hAA, "R9");
    rd_expect(8'hA1, 6, 16'h4900, 8'h00, "R9");

    // R5 low addresses in mode
    pwr(16'h0123, 8'h77, "R5");
    rd_expect(8'hAD, 4, 16'h0123, 8'h77, "R5");
    pwr(16'h18FF, 8'h44, "R5");
    rd_expect(8'hAD, 4, 16'h08FF, 8'h44, "R5");

    // R2 non-matching long opcode
    instr(8'hA5, 8, 16'h1B05, 8'h99, 1'b0, 1'b1, "R2");
    rd_expect(8'hA5, 8, 16'h1B05, 8'h99, "R2");

    // R3 matching but short
    instr(8'hA1, 5, 16'h1D10, 8'h66, 1'b0, 1'b1, "R3");
    rd_expect(8'hAD, 4, 16'h0D10, 8'h66, "R3");

    // R1 explicit timing and R10 dropped access
    cyc(1'b1, 16'h0, 8'h81, 1'b0, 1'b0, "R1");
    for (int k = 2; k <= 5; k++) cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, "R1");
    chk("R1", "pix_mode cycle 5", {7'd0, pix_mode}, 8'h00);
    cyc(1'b0, 16'h1B05, 8'h03, 1'b0, 1'b1, "R1");
    chk("R1", "pix_mode cycle 6", {7'd0, pix_mode}, 8'h01);
    cyc(1'b0, 16'h0200, 8'h22, 1'b0, 1'b1, "R10");
    cyc(1'b1, 16'h0, 8'hEA, 1'b0, 1'b0, "R1");
    chk("R1", "pix_mode at fetch", {7'd0, pix_mode}, 8'h00);
    cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, "R1");
    rd_expect(8'hAD, 4, 16'h0200, 8'h11, "R10");
    rd_expect(8'hA1, 6, 16'h1B05, 8'h03, "R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule